// File: doc/BRIEF.md
# Directory State Update Decision Unit

This block is the decision end of a directory pipeline stage. For each message it first settles the line's present coherence state, sharer set and owner. A hit in the transaction table takes precedence, then a hit in the tag/directory cache, then the replacement entry. With none of the three, it falls back to a "not cached" default. It then combines that present state with the next state and action flags from an external protocol decoder, and decides which structure holds the line next.

A line in a non-stable state lives in the transaction table. A line in a stable state lives in the cache. The unit therefore raises allocate, update or deallocate strobes for the table, together with the entry index to write. It raises allocate, update or deallocate strobes for the cache. It also says when the victim currently held in the selected way must be pushed into the replacement queue. The victim is overwritten in place, and its entry is not freed first.

The unit also produces the write data: the next state, the sharer set and owner after the decoder's actions, and the message address. All strobes and data are registered, so they appear one clock after the inputs that caused them.

Top module: `dir_update_decider`

## Requirements
- R1: Every output is registered. It reflects the inputs present at the previous rising clock edge. While rst_ni is low, all outputs are zero.
- R2: When msg_valid_i is low, none of the strobes (table allocate/update/deallocate/write, cache allocate/update/deallocate/write, victim push) is asserted in the following cycle.
- R3: The present state, sharers and owner are taken from the table when tbl_hit_i is set. Otherwise they come from the cache when cache_hit_i is set, then from the replacement entry when msg_is_repl_i is set, and otherwise from the default.
- R4: The default present state is N, encoded 3'b000, with no sharers and the owner equal to the memory tile ID (parameter MEM_TILE_ID, by default TILES).
- R5: States are 3 bits wide. A state is stable when bit 2 is 0 (N=0, I=1, S=2, M=3) and non-stable when bit 2 is 1 (4..7).
- R6: The action vector act_i has these bits: 0 owner clear, 1 owner set to requester, 2 add owner to sharers, 3 add requester to sharers, 4 clear sharers, 5 remove requester from sharers, 6 store data, 7 invalidate way. The info-change condition holds when the next state differs from the present state or any of bits 0..5 is set.
- R7: The unit raises table allocate on a stable-to-non-stable move and table deallocate on a non-stable-to-stable move. It raises table update when both states are non-stable and info-change holds. tbl_we_o is the OR of the three. tbl_valid_o is high when allocate or update is raised.
- R8: tbl_idx_o is tbl_free_idx_i when table allocate is raised, and tbl_idx_i otherwise.
- R9: Cache update is raised when the present and next states are both stable, there is a cache hit, and either info-change holds or act_i bit 6 is set.
- R10: Cache deallocate is raised when table allocate holds together with a cache hit.
- R11: Cache allocate is raised under three conditions taken together. The next state must be stable. Info-change or act_i bit 6 must hold. Cache update must not be raised, and table deallocate must not coincide with act_i bit 7.
- R12: A victim push is raised for a valid, non-replacement message that misses the cache on a valid way, when cache allocate or cache update holds and cache deallocate does not.
- R13: For a replacement message, all cache strobes and the victim push are low. cache_line_valid_o is the inverse of act_i bit 7.
- R14: wr_owner_o is req_id_i when act_i bit 1 is set, else MEM_TILE_ID when bit 0 is set, else the present owner. wr_sharers_o is built in three steps. It starts from the present sharers, or from zero when bit 4 is set. It then gains the one-hot bit of the present owner (bit 2) and of the requester (bit 3). Finally it loses the requester's bit when bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message in this stage is valid |
| msg_is_repl_i | input | 1 | Message is a replacement |
| msg_addr_i | input | ADDR_W | Line address of the message |
| req_id_i | input | OWNER_W | Requester tile ID |
| tbl_hit_i | input | 1 | Transaction table lookup hit |
| tbl_idx_i | input | IDX_W | Index of the table entry that hit |
| tbl_free_idx_i | input | IDX_W | First free table index |
| tbl_state_i | input | 3 | Table entry state |
| tbl_sharers_i | input | TILES | Table entry sharers |
| tbl_owner_i | input | OWNER_W | Table entry owner |
| cache_hit_i | input | 1 | Tag/directory cache hit |
| cache_way_valid_i | input | 1 | Selected cache way holds a valid line |
| cache_state_i | input | 3 | Cached state |
| cache_sharers_i | input | TILES | Cached sharers |
| cache_owner_i | input | OWNER_W | Cached owner |
| repl_state_i | input | 3 | Replacement entry state |
| repl_sharers_i | input | TILES | Replacement entry sharers |
| repl_owner_i | input | OWNER_W | Replacement entry owner |
| next_state_i | input | 3 | Next state from protocol decoder |
| act_i | input | 8 | Action flags from protocol decoder |
| tbl_we_o | output | 1 | Table write |
| tbl_alloc_o | output | 1 | Table allocate |
| tbl_upd_o | output | 1 | Table update |
| tbl_dealloc_o | output | 1 | Table deallocate |
| tbl_idx_o | output | IDX_W | Table index to write |
| tbl_valid_o | output | 1 | Valid bit written to the table entry |
| cache_we_o | output | 1 | Cache write |
| cache_alloc_o | output | 1 | Cache allocate |
| cache_upd_o | output | 1 | Cache update |
| cache_dealloc_o | output | 1 | Cache deallocate |
| cache_line_valid_o | output | 1 | Valid bit written to the cache way |
| victim_push_o | output | 1 | Push the way's victim into the replacement queue |
| wr_addr_o | output | ADDR_W | Address of the write |
| wr_state_o | output | 3 | State to write |
| wr_sharers_o | output | TILES | Sharers to write |
| wr_owner_o | output | OWNER_W | Owner to write |

## Verification
Two sets of commands fire together in the same cycle. Leaving the table for a stable state raises table deallocate and cache allocate at once, and a miss on a valid way adds a victim push in that same cycle. Entering a non-stable state from a cache hit raises table allocate together with cache deallocate. Vectors drive exactly these moves, with the invalidate-way flag set and cleared and the way valid and empty, and each cycle's full strobe pattern is compared against a hand-derived value. A separate vector makes the table and the cache hit together with different states, so the strobe pattern shows which source won.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  localparam int unsigned ST_W  = 3;
  localparam int unsigned ACT_W = 8;

  typedef enum logic [ST_W-1:0] {
    ST_N    = 3'd0,
    ST_I    = 3'd1,
    ST_S    = 3'd2,
    ST_M    = 3'd3,
    ST_MN_A = 3'd4,
    ST_SN_A = 3'd5,
    ST_NS_D = 3'd6,
    ST_S_D  = 3'd7
  } dir_state_e;

  // action vector bit positions
  localparam int unsigned A_OWN_CLR = 0;
  localparam int unsigned A_OWN_REQ = 1;
  localparam int unsigned A_SH_OWN  = 2;
  localparam int unsigned A_SH_REQ  = 3;
  localparam int unsigned A_SH_CLR  = 4;
  localparam int unsigned A_SH_RM   = 5;
  localparam int unsigned A_STORE   = 6;
  localparam int unsigned A_INVAL   = 7;

  function automatic logic st_stable(logic [ST_W-1:0] s);
    return ~s[ST_W-1];
  endfunction
endpackage

// File: rtl/dsu_src_select.sv
module dsu_src_select
  import dsu_pkg::*;
#(
  parameter int unsigned TILES   = 8,
  parameter int unsigned OWNER_W = 4,
  parameter logic [OWNER_W-1:0] MEM_ID = '0
) (
  input  logic               tbl_hit_i,
  input  logic [ST_W-1:0]    tbl_state_i,
  input  logic [TILES-1:0]   tbl_sharers_i,
  input  logic [OWNER_W-1:0] tbl_owner_i,
  input  logic               cache_hit_i,
  input  logic [ST_W-1:0]    cache_state_i,
  input  logic [TILES-1:0]   cache_sharers_i,
  input  logic [OWNER_W-1:0] cache_owner_i,
  input  logic               is_repl_i,
  input  logic [ST_W-1:0]    repl_state_i,
  input  logic [TILES-1:0]   repl_sharers_i,
  input  logic [OWNER_W-1:0] repl_owner_i,
  output logic [ST_W-1:0]    cur_state_o,
  output logic [TILES-1:0]   cur_sharers_o,
  output logic [OWNER_W-1:0] cur_owner_o
);
  always_comb begin
    if (tbl_hit_i) begin
      cur_state_o   = tbl_state_i;
      cur_sharers_o = tbl_sharers_i;
      cur_owner_o   = tbl_owner_i;
    end else if (cache_hit_i) begin
      cur_state_o   = cache_state_i;
      cur_sharers_o = cache_sharers_i;
      cur_owner_o   = cache_owner_i;
    end else if (is_repl_i) begin
      cur_state_o   = repl_state_i;
      cur_sharers_o = repl_sharers_i;
      cur_owner_o   = repl_owner_i;
    end else begin
      cur_state_o   = ST_N;
      cur_sharers_o = '0;
      cur_owner_o   = MEM_ID;
    end
  end
endmodule

// File: rtl/dsu_info_calc.sv
module dsu_info_calc
  import dsu_pkg::*;
#(
  parameter int unsigned TILES   = 8,
  parameter int unsigned OWNER_W = 4,
  parameter logic [OWNER_W-1:0] MEM_ID = '0
) (
  input  logic [ST_W-1:0]    cur_state_i,
  input  logic [TILES-1:0]   cur_sharers_i,
  input  logic [OWNER_W-1:0] cur_owner_i,
  input  logic [ST_W-1:0]    next_state_i,
  input  logic [ACT_W-1:0]   act_i,
  input  logic [OWNER_W-1:0] req_id_i,
  output logic               info_chg_o,
  output logic [TILES-1:0]   new_sharers_o,
  output logic [OWNER_W-1:0] new_owner_o
);
  logic [TILES-1:0] owner_oh, req_oh;

  // IDs outside 0..TILES-1 (the memory tile) map to no sharer bit
  for (genvar t = 0; t < TILES; t++) begin : g_oh
    assign owner_oh[t] = (cur_owner_i == OWNER_W'(t));
    assign req_oh[t]   = (req_id_i    == OWNER_W'(t));
  end

  assign info_chg_o = (cur_state_i != next_state_i) | act_i[A_OWN_CLR] | act_i[A_OWN_REQ]
                    | act_i[A_SH_OWN] | act_i[A_SH_REQ] | act_i[A_SH_CLR] | act_i[A_SH_RM];

  always_comb begin
    new_sharers_o = act_i[A_SH_CLR] ? '0 : cur_sharers_i;
    if (act_i[A_SH_OWN]) new_sharers_o = new_sharers_o | owner_oh;
    if (act_i[A_SH_REQ]) new_sharers_o = new_sharers_o | req_oh;
    if (act_i[A_SH_RM])  new_sharers_o = new_sharers_o & ~req_oh;
  end

  always_comb begin
    if (act_i[A_OWN_REQ])      new_owner_o = req_id_i;
    else if (act_i[A_OWN_CLR]) new_owner_o = MEM_ID;
    else                       new_owner_o = cur_owner_i;
  end
endmodule

// File: rtl/dsu_table_ctl.sv
module dsu_table_ctl #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             cur_stable_i,
  input  logic             nxt_stable_i,
  input  logic             info_chg_i,
  input  logic [IDX_W-1:0] free_idx_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  output logic             alloc_o,
  output logic             upd_o,
  output logic             dealloc_o,
  output logic             entry_valid_o,
  output logic [IDX_W-1:0] idx_o
);
  assign alloc_o       =  cur_stable_i & ~nxt_stable_i;
  assign dealloc_o     = ~cur_stable_i &  nxt_stable_i;
  assign upd_o         = ~cur_stable_i & ~nxt_stable_i & info_chg_i;
  assign entry_valid_o = (alloc_o | upd_o) & ~dealloc_o;
  assign idx_o         = alloc_o ? free_idx_i : hit_idx_i;
endmodule

// File: rtl/dsu_cache_ctl.sv
module dsu_cache_ctl (
  input  logic msg_valid_i,
  input  logic is_repl_i,
  input  logic cur_stable_i,
  input  logic nxt_stable_i,
  input  logic info_chg_i,
  input  logic store_i,
  input  logic inval_i,
  input  logic cache_hit_i,
  input  logic way_valid_i,
  input  logic tbl_alloc_i,
  input  logic tbl_dealloc_i,
  output logic alloc_o,
  output logic upd_o,
  output logic dealloc_o,
  output logic line_valid_o,
  output logic victim_o
);
  logic upd_raw, alloc_raw, dealloc_raw, chg_or_store, issue;

  assign chg_or_store = info_chg_i | store_i;
  assign upd_raw      = cur_stable_i & nxt_stable_i & cache_hit_i & chg_or_store;
  assign dealloc_raw  = tbl_alloc_i & cache_hit_i;
  assign alloc_raw    = nxt_stable_i & chg_or_store & ~(tbl_dealloc_i & inval_i) & ~upd_raw;

  // replacements never touch the cache arrays
  assign issue        = msg_valid_i & ~is_repl_i;
  assign alloc_o      = issue & alloc_raw;
  assign upd_o        = issue & upd_raw;
  assign dealloc_o    = issue & dealloc_raw;
  assign line_valid_o = ~inval_i;

  // way is overwritten in place; its old content goes to the queue
  assign victim_o = issue & way_valid_i & ~cache_hit_i & (alloc_raw | upd_raw) & ~dealloc_raw;
endmodule

// File: rtl/dir_update_decider.sv
module dir_update_decider
  import dsu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned TILES     = 8,
  parameter int unsigned TBL_DEPTH = 8,
  localparam int unsigned OWNER_W  = $clog2(TILES) + 1,
  localparam int unsigned IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  parameter logic [OWNER_W-1:0] MEM_TILE_ID = OWNER_W'(TILES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic               msg_is_repl_i,
  input  logic [ADDR_W-1:0]  msg_addr_i,
  input  logic [OWNER_W-1:0] req_id_i,
  input  logic               tbl_hit_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [IDX_W-1:0]   tbl_free_idx_i,
  input  logic [2:0]         tbl_state_i,
  input  logic [TILES-1:0]   tbl_sharers_i,
  input  logic [OWNER_W-1:0] tbl_owner_i,
  input  logic               cache_hit_i,
  input  logic               cache_way_valid_i,
  input  logic [2:0]         cache_state_i,
  input  logic [TILES-1:0]   cache_sharers_i,
  input  logic [OWNER_W-1:0] cache_owner_i,
  input  logic [2:0]         repl_state_i,
  input  logic [TILES-1:0]   repl_sharers_i,
  input  logic [OWNER_W-1:0] repl_owner_i,
  input  logic [2:0]         next_state_i,
  input  logic [7:0]         act_i,
  output logic               tbl_we_o,
  output logic               tbl_alloc_o,
  output logic               tbl_upd_o,
  output logic               tbl_dealloc_o,
  output logic [IDX_W-1:0]   tbl_idx_o,
  output logic               tbl_valid_o,
  output logic               cache_we_o,
  output logic               cache_alloc_o,
  output logic               cache_upd_o,
  output logic               cache_dealloc_o,
  output logic               cache_line_valid_o,
  output logic               victim_push_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [2:0]         wr_state_o,
  output logic [TILES-1:0]   wr_sharers_o,
  output logic [OWNER_W-1:0] wr_owner_o
);
  logic [ST_W-1:0]    cur_state;
  logic [TILES-1:0]   cur_sharers, new_sharers;
  logic [OWNER_W-1:0] cur_owner, new_owner;
  logic               info_chg, cur_stable, nxt_stable;
  logic               t_alloc, t_upd, t_dealloc, t_valid;
  logic [IDX_W-1:0]   t_idx;
  logic               c_alloc, c_upd, c_dealloc, c_line_valid, c_victim;

  dsu_src_select #(.TILES(TILES), .OWNER_W(OWNER_W), .MEM_ID(MEM_TILE_ID)) u_src (
    .tbl_hit_i       (tbl_hit_i),
    .tbl_state_i     (tbl_state_i),
    .tbl_sharers_i   (tbl_sharers_i),
    .tbl_owner_i     (tbl_owner_i),
    .cache_hit_i     (cache_hit_i),
    .cache_state_i   (cache_state_i),
    .cache_sharers_i (cache_sharers_i),
    .cache_owner_i   (cache_owner_i),
    .is_repl_i       (msg_is_repl_i),
    .repl_state_i    (repl_state_i),
    .repl_sharers_i  (repl_sharers_i),
    .repl_owner_i    (repl_owner_i),
    .cur_state_o     (cur_state),
    .cur_sharers_o   (cur_sharers),
    .cur_owner_o     (cur_owner)
  );

  dsu_info_calc #(.TILES(TILES), .OWNER_W(OWNER_W), .MEM_ID(MEM_TILE_ID)) u_info (
    .cur_state_i   (cur_state),
    .cur_sharers_i (cur_sharers),
    .cur_owner_i   (cur_owner),
    .next_state_i  (next_state_i),
    .act_i         (act_i),
    .req_id_i      (req_id_i),
    .info_chg_o    (info_chg),
    .new_sharers_o (new_sharers),
    .new_owner_o   (new_owner)
  );

  assign cur_stable = st_stable(cur_state);
  assign nxt_stable = st_stable(next_state_i);

  dsu_table_ctl #(.IDX_W(IDX_W)) u_tbl (
    .cur_stable_i  (cur_stable),
    .nxt_stable_i  (nxt_stable),
    .info_chg_i    (info_chg),
    .free_idx_i    (tbl_free_idx_i),
    .hit_idx_i     (tbl_idx_i),
    .alloc_o       (t_alloc),
    .upd_o         (t_upd),
    .dealloc_o     (t_dealloc),
    .entry_valid_o (t_valid),
    .idx_o         (t_idx)
  );

  dsu_cache_ctl u_cache (
    .msg_valid_i   (msg_valid_i),
    .is_repl_i     (msg_is_repl_i),
    .cur_stable_i  (cur_stable),
    .nxt_stable_i  (nxt_stable),
    .info_chg_i    (info_chg),
    .store_i       (act_i[A_STORE]),
    .inval_i       (act_i[A_INVAL]),
    .cache_hit_i   (cache_hit_i),
    .way_valid_i   (cache_way_valid_i),
    .tbl_alloc_i   (t_alloc),
    .tbl_dealloc_i (t_dealloc),
    .alloc_o       (c_alloc),
    .upd_o         (c_upd),
    .dealloc_o     (c_dealloc),
    .line_valid_o  (c_line_valid),
    .victim_o      (c_victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_we_o           <= 1'b0;
      tbl_alloc_o        <= 1'b0;
      tbl_upd_o          <= 1'b0;
      tbl_dealloc_o      <= 1'b0;
      tbl_idx_o          <= '0;
      tbl_valid_o        <= 1'b0;
      cache_we_o         <= 1'b0;
      cache_alloc_o      <= 1'b0;
      cache_upd_o        <= 1'b0;
      cache_dealloc_o    <= 1'b0;
      cache_line_valid_o <= 1'b0;
      victim_push_o      <= 1'b0;
      wr_addr_o          <= '0;
      wr_state_o         <= '0;
      wr_sharers_o       <= '0;
      wr_owner_o         <= '0;
    end else begin
      tbl_alloc_o        <= msg_valid_i & t_alloc;
      tbl_upd_o          <= msg_valid_i & t_upd;
      tbl_dealloc_o      <= msg_valid_i & t_dealloc;
      tbl_we_o           <= msg_valid_i & (t_alloc | t_upd | t_dealloc);
      tbl_valid_o        <= t_valid;
      tbl_idx_o          <= t_idx;
      cache_alloc_o      <= c_alloc;
      cache_upd_o        <= c_upd;
      cache_dealloc_o    <= c_dealloc;
      cache_we_o         <= c_alloc | c_upd | c_dealloc;
      cache_line_valid_o <= c_line_valid;
      victim_push_o      <= c_victim;
      wr_addr_o          <= msg_addr_i;
      wr_state_o         <= next_state_i;
      wr_sharers_o       <= new_sharers;
      wr_owner_o         <= new_owner;
    end
  end
endmodule

// File: rtl/dir_update_decider_chk.sv
module dir_update_decider_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_valid_i,
  input logic             msg_is_repl_i,
  input logic [IDX_W-1:0] tbl_free_idx_i,
  input logic             tbl_alloc_o,
  input logic             tbl_upd_o,
  input logic             tbl_dealloc_o,
  input logic             tbl_we_o,
  input logic [IDX_W-1:0] tbl_idx_o,
  input logic             cache_alloc_o,
  input logic             cache_upd_o,
  input logic             cache_dealloc_o,
  input logic             cache_we_o,
  input logic             victim_push_o,
  input logic [2:0]       wr_state_o
);
  assert_quiet_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(msg_valid_i) |-> !(tbl_we_o || cache_we_o || victim_push_o));

  assert_tbl_ops_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tbl_alloc_o, tbl_upd_o, tbl_dealloc_o}));

  assert_alloc_uses_free_idx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_alloc_o |-> tbl_idx_o == $past(tbl_free_idx_i));

  assert_cache_upd_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_upd_o |-> !wr_state_o[2]);

  assert_cache_ops_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cache_alloc_o, cache_upd_o, cache_dealloc_o}));

  assert_victim_with_fill_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_push_o |-> (cache_alloc_o || cache_upd_o) && !cache_dealloc_o);

  assert_repl_skips_cache_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_is_repl_i) |=> !(cache_we_o || victim_push_o));
endmodule

bind dir_update_decider dir_update_decider_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .msg_valid_i     (msg_valid_i),
  .msg_is_repl_i   (msg_is_repl_i),
  .tbl_free_idx_i  (tbl_free_idx_i),
  .tbl_alloc_o     (tbl_alloc_o),
  .tbl_upd_o       (tbl_upd_o),
  .tbl_dealloc_o   (tbl_dealloc_o),
  .tbl_we_o        (tbl_we_o),
  .tbl_idx_o       (tbl_idx_o),
  .cache_alloc_o   (cache_alloc_o),
  .cache_upd_o     (cache_upd_o),
  .cache_dealloc_o (cache_dealloc_o),
  .cache_we_o      (cache_we_o),
  .victim_push_o   (victim_push_o),
  .wr_state_o      (wr_state_o)
);

// File: tb/dir_update_decider_tb_top.sv
module dir_update_decider_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned TILES  = 8;
  localparam int unsigned OW     = 4;
  localparam int unsigned IW     = 3;
  localparam logic [OW-1:0] MEM  = 4'd8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic              msg_valid_i, msg_is_repl_i;
  logic [ADDR_W-1:0] msg_addr_i;
  logic [OW-1:0]     req_id_i;
  logic              tbl_hit_i, cache_hit_i, cache_way_valid_i;
  logic [IW-1:0]     tbl_idx_i, tbl_free_idx_i;
  logic [2:0]        tbl_state_i, cache_state_i, repl_state_i, next_state_i;
  logic [TILES-1:0]  tbl_sharers_i, cache_sharers_i, repl_sharers_i;
  logic [OW-1:0]     tbl_owner_i, cache_owner_i, repl_owner_i;
  logic [7:0]        act_i;
  logic              tbl_we_o, tbl_alloc_o, tbl_upd_o, tbl_dealloc_o, tbl_valid_o;
  logic [IW-1:0]     tbl_idx_o;
  logic              cache_we_o, cache_alloc_o, cache_upd_o, cache_dealloc_o;
  logic              cache_line_valid_o, victim_push_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [2:0]        wr_state_o;
  logic [TILES-1:0]  wr_sharers_o;
  logic [OW-1:0]     wr_owner_o;

  dir_update_decider dut_i (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {th, ch, wv, rp, tbl_state, cache_state, repl_state, next_state, act, expected strobes}
  // strobes: {tbl_alloc, tbl_upd, tbl_dealloc, c_alloc, c_upd, c_dealloc, victim, tbl_valid}
  typedef struct packed {
    logic th, ch, wv, rp;
    logic [2:0] ts, cs, rs, ns;
    logic [7:0] act;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0,3'd0,3'd6, 8'h00, 8'h81}, // R7 alloc from N
    '{1'b1,1'b0,1'b1,1'b0, 3'd6,3'd0,3'd0,3'd2, 8'h08, 8'h32}, // R7 R11 R12 dealloc+alloc+victim
    '{1'b1,1'b0,1'b1,1'b0, 3'd6,3'd0,3'd0,3'd2, 8'h88, 8'h20}, // R11 invalidate blocks alloc
    '{1'b0,1'b1,1'b1,1'b0, 3'd0,3'd2,3'd0,3'd3, 8'h03, 8'h08}, // R9 S->M update
    '{1'b0,1'b1,1'b1,1'b0, 3'd0,3'd3,3'd0,3'd3, 8'h40, 8'h08}, // R9 store-only update
    '{1'b0,1'b1,1'b1,1'b0, 3'd0,3'd3,3'd0,3'd3, 8'h00, 8'h00}, // R6 no change
    '{1'b0,1'b1,1'b1,1'b0, 3'd0,3'd3,3'd0,3'd4, 8'h00, 8'h85}, // R10 cache dealloc
    '{1'b1,1'b0,1'b0,1'b0, 3'd4,3'd0,3'd0,3'd4, 8'h20, 8'h41}, // R7 table update
    '{1'b1,1'b0,1'b0,1'b0, 3'd4,3'd0,3'd0,3'd4, 8'h00, 8'h00}, // R6 no info change
    '{1'b0,1'b0,1'b0,1'b1, 3'd0,3'd0,3'd2,3'd5, 8'h10, 8'h81}, // R3 R13 repl source
    '{1'b0,1'b1,1'b1,1'b1, 3'd0,3'd3,3'd0,3'd3, 8'h40, 8'h00}, // R13 repl suppresses cache
    '{1'b1,1'b1,1'b1,1'b0, 3'd7,3'd2,3'd0,3'd2, 8'h00, 8'h30}, // R3 table beats cache
    '{1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0,3'd0,3'd2, 8'h48, 8'h10}, // R11 alloc, empty way
    '{1'b0,1'b0,1'b1,1'b0, 3'd0,3'd0,3'd0,3'd2, 8'h48, 8'h12}  // R12 alloc, victim
  };

  task automatic drive(input logic v, input vec_t x);
    msg_valid_i       = v;
    tbl_hit_i         = x.th;
    cache_hit_i       = x.ch;
    cache_way_valid_i = x.wv;
    msg_is_repl_i     = x.rp;
    tbl_state_i       = x.ts;
    cache_state_i     = x.cs;
    repl_state_i      = x.rs;
    next_state_i      = x.ns;
    act_i             = x.act;
  endtask

  function automatic logic [7:0] strobes();
    return {tbl_alloc_o, tbl_upd_o, tbl_dealloc_o, cache_alloc_o,
            cache_upd_o, cache_dealloc_o, victim_push_o, tbl_valid_o};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    vec_t d;
    msg_addr_i = 32'h0000_1240; req_id_i = 4'd5;
    tbl_idx_i = 3'd2; tbl_free_idx_i = 3'd5;
    tbl_sharers_i = 8'h01; cache_sharers_i = 8'h06; repl_sharers_i = 8'h80;
    tbl_owner_i = 4'd1; cache_owner_i = 4'd2; repl_owner_i = 4'd3;
    drive(1'b1, VECS[0]);
    repeat (3) @(negedge clk_i);
    // R1: reset holds outputs at zero
    chk("R1 reset strobes", {24'd0, strobes()}, 32'd0);
    chk("R1 reset data", {wr_state_o, wr_sharers_o, wr_owner_o, tbl_idx_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i]);
      @(negedge clk_i);
      chk($sformatf("R7-R13 vec%0d strobes", i), {24'd0, strobes()}, {24'd0, VECS[i].exp});
      chk($sformatf("R8 vec%0d idx", i), {29'd0, tbl_idx_o}, VECS[i].exp[7] ? 32'd5 : 32'd2);
    end

    // R2: valid low, conditions for allocation otherwise present
    drive(1'b0, VECS[1]);
    @(negedge clk_i);
    chk("R2 idle strobes", {29'd0, tbl_we_o, cache_we_o, victim_push_o}, 32'd0);

    // R3/R4: source priority seen through owner and sharers
    d = '0; d.th = 1; d.ch = 1; d.rp = 1;
    drive(1'b1, d); @(negedge clk_i);
    chk("R3 table owner", {28'd0, wr_owner_o}, 32'd1);
    d.th = 0; drive(1'b1, d); @(negedge clk_i);
    chk("R3 cache owner", {28'd0, wr_owner_o}, 32'd2);
    d.ch = 0; drive(1'b1, d); @(negedge clk_i);
    chk("R3 repl owner", {28'd0, wr_owner_o}, 32'd3);
    chk("R3 repl sharers", {24'd0, wr_sharers_o}, 32'h80);
    d.rp = 0; drive(1'b1, d); @(negedge clk_i);
    chk("R4 default owner", {28'd0, wr_owner_o}, {28'd0, MEM});
    chk("R4 default sharers", {24'd0, wr_sharers_o}, 32'd0);
    // R5: N to N stable with no actions gives no strobes
    chk("R5 N stays stable", {24'd0, strobes()}, 32'd0);

    // R14: sharer and owner actions on cached line (sharers 0x06, owner 2, req 5)
    d = '0; d.ch = 1; d.cs = 3'd3; d.ns = 3'd3;
    d.act = 8'h08; drive(1'b1, d); @(negedge clk_i);
    chk("R14 add requester", {24'd0, wr_sharers_o}, 32'h26);
    d.act = 8'h14; drive(1'b1, d); @(negedge clk_i);
    chk("R14 clear then add owner", {24'd0, wr_sharers_o}, 32'h04);
    d.act = 8'h2C; drive(1'b1, d); @(negedge clk_i);
    chk("R14 remove wins over add", {24'd0, wr_sharers_o}, 32'h06);
    d.act = 8'h01; drive(1'b1, d); @(negedge clk_i);
    chk("R14 owner clear", {28'd0, wr_owner_o}, {28'd0, MEM});
    d.act = 8'h03; drive(1'b1, d); @(negedge clk_i);
    chk("R14 owner set requester", {28'd0, wr_owner_o}, 32'd5);
    chk("R6 owner action is info change", {31'd0, cache_upd_o}, 32'd1);

    // R13: invalidate-way drives cache line valid low on update M->I
    d.act = 8'h80; d.ns = 3'd1; drive(1'b1, d); @(negedge clk_i);
    chk("R13 line valid cleared", {30'd0, cache_upd_o, cache_line_valid_o}, 32'd2);
    chk("R9 write state", {29'd0, wr_state_o}, 32'd1);

    // R1: address captured one cycle later
    msg_addr_i = 32'hCAFE_0080; @(negedge clk_i);
    chk("R1 address latency", wr_addr_o, 32'hCAFE_0080);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule